// File: doc/BRIEF.md
# Two-Level Lookahead Adder-Subtractor

This block adds or subtracts two 16-bit two's-complement operands in a single combinational pass. One control input selects the operation. For subtraction, the second operand is inverted bit by bit and a carry of one is injected at the least significant bit. The block returns the 16-bit result, the unsigned carry out of the top bit and a signed overflow flag.

Carries are never rippled. Every bit forms a generate and a propagate term. Propagate is taken as the XOR of the two operand bits, so the same signal also feeds the sum XOR. Inside each 4-bit group, a lookahead unit expands each carry into a flat sum of products. The same kind of unit works one level up, on the group generate and propagate terms, and produces the carry into every group at once. The final carry comes from the block-level generate and propagate terms. Overflow is the XOR of the carry out of the top bit and the carry into the top bit.

The block has no clock and no state. Its outputs follow its inputs through gates only, so it can sit between two pipeline registers of a datapath.

Top module: `lka_addsub`

## Requirements
- R1: With `sub_en` = 0, `sum_out` equals (`x_in` + `y_in`) modulo 2^16.
- R2: With `sub_en` = 1, `sum_out` equals (`x_in` − `y_in`) modulo 2^16.
- R3: With `sub_en` = 0, `carry_out` is bit 16 of the unsigned 17-bit sum of `x_in` and `y_in`.
- R4: With `sub_en` = 1, `carry_out` is 1 exactly when `x_in` ≥ `y_in` as unsigned numbers, for example 0 − 0 gives `carry_out` = 1.
- R5: `ovf_out` is 1 exactly when the true signed result of the selected operation lies outside −32768..32767. For example, 0x7FFF + 1 and 0x8000 − 1 both set it.
- R6: A carry crosses every bit and group boundary within the same evaluation. 0xFFFF + 0x0001 gives 0x0000 with `carry_out` = 1, and x − x gives 0 with `carry_out` = 1 for any x.
- R7: The outputs depend only on the present inputs. Applying a vector again after other vectors reproduces the same outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_in | input | 16 | First operand, two's complement |
| y_in | input | 16 | Second operand, two's complement |
| sub_en | input | 1 | 0 = add, 1 = subtract (x − y) |
| sum_out | output | 16 | Result modulo 2^16 |
| carry_out | output | 1 | Carry out of bit 15 |
| ovf_out | output | 1 | Signed overflow of the selected operation |

## Verification
Whenever the inputs settle, the bound checker compares the sum and the carry against a wide arithmetic model for both operations. It also checks the overflow flag against the sign rule, which uses the effective operand signs and the result sign rather than the carries. It also checks that subtracting an operand from itself clears the result and sets the carry. That the outputs hold no memory of earlier vectors can only be shown by the bench, which replays a vector after unrelated traffic. The bench's directed cases also check the specific corner values at the limits of the signed range.

// File: rtl/lka_pkg.sv
package lka_pkg;
    localparam int DATA_W = 16;
    localparam int GRP_W  = 4;

    typedef struct packed {
        logic carry;
        logic ovf;
    } lka_flags_t;
endpackage

// File: rtl/lka_pgcell.sv
module lka_pgcell #(
    parameter int W = 16
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic         inv_i,
    output logic [W-1:0] gen_o,
    output logic [W-1:0] prp_o
);
    logic [W-1:0] y_eff_d;

    always_comb begin
        for (int b = 0; b < W; b++) begin
            y_eff_d[b] = y_i[b] ^ inv_i;
            gen_o[b]   = x_i[b] & y_eff_d[b];
            prp_o[b]   = x_i[b] ^ y_eff_d[b];
        end
    end
endmodule

// File: rtl/lka_unit.sv
module lka_unit #(
    parameter int N = 4
) (
    input  logic [N-1:0] gen_i,
    input  logic [N-1:0] prp_i,
    input  logic         cin_i,
    output logic [N-1:0] cin_vec_o,
    output logic         blk_gen_o,
    output logic         blk_prp_o
);
    // Flat sum of products for the carry out of position top.
    function automatic logic expand(input logic [N-1:0] g, input logic [N-1:0] p,
                                    input int top, input logic c0);
        logic acc;
        logic term;
        acc  = c0;
        for (int k = 0; k <= top; k++) acc = acc & p[k];
        for (int j = 0; j <= top; j++) begin
            term = g[j];
            for (int k = j + 1; k <= top; k++) term = term & p[k];
            acc = acc | term;
        end
        return acc;
    endfunction

    always_comb begin
        cin_vec_o[0] = cin_i;
        for (int i = 0; i < N - 1; i++) begin
            cin_vec_o[i+1] = expand(gen_i, prp_i, i, cin_i);
        end
        blk_prp_o = &prp_i;
        blk_gen_o = expand(gen_i, prp_i, N - 1, 1'b0);
    end
endmodule

// File: rtl/lka_addsub.sv
module lka_addsub
    import lka_pkg::*;
#(
    parameter int WIDTH = DATA_W,
    parameter int GW    = GRP_W
) (
    input  logic [WIDTH-1:0] x_in,
    input  logic [WIDTH-1:0] y_in,
    input  logic             sub_en,
    output logic [WIDTH-1:0] sum_out,
    output logic             carry_out,
    output logic             ovf_out
);
    localparam int NGRP = WIDTH / GW;

    logic [WIDTH-1:0] gen_d;
    logic [WIDTH-1:0] prp_d;
    logic [WIDTH-1:0] carry_d;
    logic [NGRP-1:0]  grp_gen_d;
    logic [NGRP-1:0]  grp_prp_d;
    logic [NGRP-1:0]  grp_cin_d;
    logic             top_gen_d;
    logic             top_prp_d;
    logic             c_final_d;
    lka_flags_t       flags_d;

    lka_pgcell #(.W(WIDTH)) u_pg (
        .x_i   (x_in),
        .y_i   (y_in),
        .inv_i (sub_en),
        .gen_o (gen_d),
        .prp_o (prp_d)
    );

    // First level: carries inside each group.
    for (genvar k = 0; k < NGRP; k++) begin : g_grp
        lka_unit #(.N(GW)) u_lvl1 (
            .gen_i     (gen_d[k*GW +: GW]),
            .prp_i     (prp_d[k*GW +: GW]),
            .cin_i     (grp_cin_d[k]),
            .cin_vec_o (carry_d[k*GW +: GW]),
            .blk_gen_o (grp_gen_d[k]),
            .blk_prp_o (grp_prp_d[k])
        );
    end

    // Second level: all group carry-ins in parallel.
    lka_unit #(.N(NGRP)) u_lvl2 (
        .gen_i     (grp_gen_d),
        .prp_i     (grp_prp_d),
        .cin_i     (sub_en),
        .cin_vec_o (grp_cin_d),
        .blk_gen_o (top_gen_d),
        .blk_prp_o (top_prp_d)
    );

    always_comb begin
        c_final_d     = top_gen_d | (top_prp_d & sub_en);
        flags_d.carry = c_final_d;
        flags_d.ovf   = c_final_d ^ carry_d[WIDTH-1];
        sum_out       = prp_d ^ carry_d;
        carry_out     = flags_d.carry;
        ovf_out       = flags_d.ovf;
    end
endmodule

// File: rtl/lka_addsub_chk.sv
module lka_addsub_chk #(
    parameter int WIDTH = 16
) (
    input logic [WIDTH-1:0] x_in,
    input logic [WIDTH-1:0] y_in,
    input logic             sub_en,
    input logic [WIDTH-1:0] sum_out,
    input logic             carry_out,
    input logic             ovf_out
);
    logic [WIDTH:0]   wide_add;
    logic [WIDTH-1:0] diff;
    logic [WIDTH-1:0] y_eff;

    always_comb begin
        wide_add = {1'b0, x_in} + {1'b0, y_in};
        diff     = x_in - y_in;
        y_eff    = sub_en ? ~y_in : y_in;
        // R1
        add_sum_chk: assert (sub_en || sum_out == wide_add[WIDTH-1:0])
            else $error("add sum mismatch");
        // R2
        sub_sum_chk: assert (!sub_en || sum_out == diff)
            else $error("sub sum mismatch");
        // R3
        add_carry_chk: assert (sub_en || carry_out == wide_add[WIDTH])
            else $error("add carry mismatch");
        // R4
        sub_carry_chk: assert (!sub_en || carry_out == (x_in >= y_in))
            else $error("sub carry mismatch");
        // R5
        ovf_sign_chk: assert (ovf_out == ((x_in[WIDTH-1] == y_eff[WIDTH-1]) &&
                                          (sum_out[WIDTH-1] != x_in[WIDTH-1])))
            else $error("overflow flag mismatch");
        // R6
        self_sub_chk: assert (!(sub_en && x_in == y_in) || (sum_out == '0 && carry_out))
            else $error("x - x mismatch");
    end
endmodule

bind lka_addsub lka_addsub_chk #(.WIDTH(WIDTH)) u_chk (
    .x_in      (x_in),
    .y_in      (y_in),
    .sub_en    (sub_en),
    .sum_out   (sum_out),
    .carry_out (carry_out),
    .ovf_out   (ovf_out)
);

// File: tb/lka_addsub_bench.sv
module lka_addsub_bench;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic [W-1:0] x_in = '0;
    logic [W-1:0] y_in = '0;
    logic         sub_en = 1'b0;
    logic [W-1:0] sum_out;
    logic         carry_out;
    logic         ovf_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    lka_addsub u_lka_addsub (
        .x_in      (x_in),
        .y_in      (y_in),
        .sub_en    (sub_en),
        .sum_out   (sum_out),
        .carry_out (carry_out),
        .ovf_out   (ovf_out)
    );

    function automatic logic [W-1:0] exp_sum(input logic [W-1:0] a, input logic [W-1:0] b,
                                             input logic s);
        return s ? a - b : a + b;
    endfunction

    function automatic logic exp_carry(input logic [W-1:0] a, input logic [W-1:0] b,
                                       input logic s);
        logic [W:0] t;
        if (s) return (a >= b);
        t = {1'b0, a} + {1'b0, b};
        return t[W];
    endfunction

    function automatic logic exp_ovf(input logic [W-1:0] a, input logic [W-1:0] b,
                                     input logic s);
        longint sa, sb, r, hi, lo;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        r  = s ? sa - sb : sa + sb;
        hi = (longint'(1) <<< (W - 1)) - 1;
        lo = -(longint'(1) <<< (W - 1));
        return (r > hi) || (r < lo);
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: x=%h y=%h sub=%0b actual=%h expected=%h",
                     tag, x_in, y_in, sub_en, got, exp);
        end
    endtask

    task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input logic s);
        @(negedge clk);
        x_in   = a;
        y_in   = b;
        sub_en = s;
        #1;
    endtask

    task automatic check_all(input logic [W-1:0] a, input logic [W-1:0] b, input logic s);
        apply(a, b, s);
        check(s ? "R2 sum" : "R1 sum", 32'(sum_out), 32'(exp_sum(a, b, s)));
        check(s ? "R4 carry" : "R3 carry", 32'(carry_out), 32'(exp_carry(a, b, s)));
        check("R5 ovf", 32'(ovf_out), 32'(exp_ovf(a, b, s)));
    endtask

    initial begin
        logic [W-1:0] ref_sum;
        logic         ref_c;
        logic         ref_v;
        void'($urandom(32'h5A17));
        // R1 idle state: all-zero operands
        #1;
        check("R1 zero sum", 32'(sum_out), 32'h0);
        check("R3 zero carry", 32'(carry_out), 32'h0);
        check("R5 zero ovf", 32'(ovf_out), 32'h0);
        // R5 signed range limits
        check_all(16'h7FFF, 16'h0001, 1'b0);
        check_all(16'h8000, 16'h0001, 1'b1);
        check_all(16'h8000, 16'h8000, 1'b0);
        check_all(16'h0000, 16'h8000, 1'b1);
        check_all(16'h7FFF, 16'hFFFF, 1'b1);
        // R6 full carry chains
        check_all(16'hFFFF, 16'h0001, 1'b0);
        check_all(16'h0FFF, 16'h0001, 1'b0);
        check_all(16'h00FF, 16'h0F01, 1'b0);
        check_all(16'h0000, 16'h0000, 1'b1);
        check_all(16'h1234, 16'h1234, 1'b1);
        check_all(16'h0000, 16'h0001, 1'b1);
        // R7 replay a vector after other traffic
        apply(16'hA5C3, 16'h3C5A, 1'b1);
        ref_sum = sum_out;
        ref_c   = carry_out;
        ref_v   = ovf_out;
        for (int i = 0; i < 2000; i++) begin
            check_all(W'($urandom), W'($urandom), 1'($urandom));
        end
        for (int i = 0; i < 200; i++) begin
            check_all({1'b0, W'($urandom) >> 1}, {1'b0, W'($urandom) >> 1}, 1'b0);
        end
        apply(16'hA5C3, 16'h3C5A, 1'b1);
        check("R7 replay sum", 32'(sum_out), 32'(ref_sum));
        check("R7 replay carry", 32'(carry_out), 32'(ref_c));
        check("R7 replay ovf", 32'(ovf_out), 32'(ref_v));
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule